// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Compare Alarm

This block keeps wall-clock time in a 47-bit counter. The counter advances once per pulse on a slow-clock strobe, nominally 32.768 kHz. The upper 32 bits of the counter hold whole seconds and the lower 15 bits hold the fraction of a second. Software reaches the block through a small word-addressed register bus. Through it, software sets and reads the time, programs a compare alarm, starts and stops counting, reads and clears status flags, and selects which flags drive the single interrupt line.

Writes to the time, alarm, control and status registers model a slow, separately clocked domain. Each such write is held for a fixed number of cycles with a busy flag raised, then commits and raises a write-complete flag. Software learns of completion by polling status or by the interrupt. Writes to the interrupt-enable register bypass this path and act at once. The counter stays frozen after reset until software writes the seconds register for the first time. This gives software a chance to establish a valid time before the clock starts.

Top module: `sec_rtc`

## Requirements
- R1: After reset, the status word reads 0x0000_0202 (bit 1 not-valid set, bit 9 ready-for-next set). The seconds and fraction registers read 0, the alarm seconds register reads 0xFFFF_FFFF, the interrupt-enable register reads 0, and `irq` is low. The not-valid flag is never set again after it is cleared.
- R2: A write to a slow register is decoded from these offsets: 0x00 seconds, 0x04 fraction, 0x08 alarm seconds, 0x0C alarm fraction, 0x10 control, 0x14 status. It raises status bit 10 (busy) for exactly WR_LAT cycles and clears bit 9 (ready) for the same cycles. The target register keeps its old value until the commit, when it takes the new value and status bit 8 (write complete) is set.
- R3: A slow-register write that arrives while busy is set is dropped and sets status bit 7 (write error).
- R4: Any read of the status register clears write complete. If a commit falls in the same cycle as the read, the flag ends up set.
- R5: A committed write to status clears bits 7, 4 and 1 where the written data has a 1. Bits written as 0 leave those flags unchanged.
- R6: A write to the interrupt-enable register at 0x18 takes effect in the cycle it is accepted. It does not set busy and does not set write complete.
- R7: The counter advances by one on each `tick` only when control bit 3 is set and the seconds register has been written at least once. It holds otherwise.
- R8: The fraction field carries into the seconds field when it wraps past 0x7FFF.
- R9: Status bit 4 (alarm) is set when the full counter equals {alarm seconds, alarm fraction}. An alarm seconds value of 0xFFFF_FFFF never matches.
- R10: `irq` is high exactly when some status bit among 9, 8, 7 and 4 is set together with the interrupt-enable bit at the same position.
- R11: The fraction registers read back with bits 31:15 zero. The control register reads back only bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe per slow-clock period |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
A wrong busy countdown shows up at once in the busy and ready bits of the status word. It also shows up as a target register that reads back its new value too early or too late around the WR_LAT boundary. Corrupted counter state or a wrong run/started gate surfaces at the seconds and fraction registers after the next tick, and a bad carry surfaces at the 0x7FFF wrap. A wrong alarm compare or flag priority appears in status bit 4 and in `irq` one cycle after the counter reaches the alarm value. It can also appear as a write-complete flag lost when a status read meets a commit.

// File: rtl/srtc_pkg.sv
package srtc_pkg;

    localparam int DATA_W = 32;
    localparam int REG_AW = 5;

    // status / enable bit positions (software decodes these)
    localparam int B_BUSY = 10;
    localparam int B_NEXT = 9;
    localparam int B_DONE = 8;
    localparam int B_ERR  = 7;
    localparam int B_ALM  = 4;
    localparam int B_NVAL = 1;
    localparam int B_SVIO = 0;
    localparam int B_RUN  = 3;

    typedef enum logic [2:0] {
        RG_TSEC = 3'd0,
        RG_TFRC = 3'd1,
        RG_ASEC = 3'd2,
        RG_AFRC = 3'd3,
        RG_CTRL = 3'd4,
        RG_STAT = 3'd5,
        RG_IEN  = 3'd6,
        RG_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic done;
        logic err;
        logic alm;
        logic nval;
    } flag_s;

    typedef struct packed {
        logic nxt;
        logic done;
        logic err;
        logic alm;
    } ien_s;

    typedef struct packed {
        reg_sel_e           sel;
        logic [DATA_W-1:0]  data;
    } wr_req_s;

    function automatic reg_sel_e decode_addr(input logic [REG_AW-1:0] a);
        reg_sel_e r;
        if (a[1:0] != 2'b00) begin
            r = RG_NONE;
        end else begin
            case (a[4:2])
                3'd0:    r = RG_TSEC;
                3'd1:    r = RG_TFRC;
                3'd2:    r = RG_ASEC;
                3'd3:    r = RG_AFRC;
                3'd4:    r = RG_CTRL;
                3'd5:    r = RG_STAT;
                3'd6:    r = RG_IEN;
                default: r = RG_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic logic is_slow(input reg_sel_e r);
        return (r != RG_IEN) && (r != RG_NONE);
    endfunction

endpackage

// File: rtl/srtc_wrq.sv
module srtc_wrq
    import srtc_pkg::*;
#(
    parameter int WR_LAT = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  wr_req_s req,
    output logic    busy,
    output logic    commit,
    output wr_req_s held,
    output logic    collide
);
    localparam int CNT_W = $clog2(WR_LAT + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
            held   <= '{sel: RG_NONE, data: '0};
        end else if (busy) begin
            if (remain == '0) begin
                busy <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end else if (req_valid) begin
            busy   <= 1'b1;
            remain <= CNT_W'(WR_LAT - 1);
            held   <= req;
        end
    end

    assign commit  = busy && (remain == '0);
    assign collide = busy && req_valid;

endmodule

// File: rtl/srtc_count.sv
module srtc_count #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    run,
    input  logic                    load_sec,
    input  logic                    load_frc,
    input  logic [SEC_W-1:0]        sec_val,
    input  logic [FRAC_W-1:0]       frc_val,
    output logic [SEC_W+FRAC_W-1:0] count,
    output logic                    started
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            started <= 1'b0;
        end else if (load_sec) begin
            count[SEC_W+FRAC_W-1:FRAC_W] <= sec_val;
            started <= 1'b1;
        end else if (load_frc) begin
            count[FRAC_W-1:0] <= frc_val;
        end else if (tick && run && started) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/srtc_flags.sv
module srtc_flags
    import srtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  commit,
    input  logic  commit_stat,
    input  logic  clr_err,
    input  logic  clr_alm,
    input  logic  clr_nval,
    input  logic  collide,
    input  logic  alarm_hit,
    input  logic  stat_rd,
    input  logic  busy,
    input  ien_s  ien,
    output flag_s flg,
    output logic  irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flg <= '{done: 1'b0, err: 1'b0, alm: 1'b0, nval: 1'b1};
        end else begin
            if (commit)       flg.done <= 1'b1;
            else if (stat_rd) flg.done <= 1'b0;

            if (collide)                      flg.err <= 1'b0 | 1'b1;
            else if (commit_stat && clr_err)  flg.err <= 1'b0;

            if (alarm_hit)                    flg.alm <= 1'b1;
            else if (commit_stat && clr_alm)  flg.alm <= 1'b0;

            if (commit_stat && clr_nval)      flg.nval <= 1'b0;
        end
    end

    assign irq = (ien.nxt  && !busy)
               | (ien.done && flg.done)
               | (ien.err  && flg.err)
               | (ien.alm  && flg.alm);

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import srtc_pkg::*;
#(
    parameter int FRAC_W = 15,
    parameter int WR_LAT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int SEC_W = DATA_W;
    localparam int CW    = SEC_W + FRAC_W;

    reg_sel_e          asel;
    logic              slow_wr, ien_wr, stat_rd;
    logic              busy, commit, collide, started, ctl_run, alarm_hit;
    wr_req_s           held;
    logic [CW-1:0]     count;
    logic [SEC_W-1:0]  alm_sec;
    logic [FRAC_W-1:0] alm_frc;
    ien_s              ien;
    flag_s             flg;
    logic              commit_stat;
    logic [DATA_W-1:0] stat_word;

    assign asel    = decode_addr(bus_addr);
    assign slow_wr = bus_sel && bus_we && is_slow(asel);
    assign ien_wr  = bus_sel && bus_we && (asel == RG_IEN);
    assign stat_rd = bus_sel && !bus_we && (asel == RG_STAT);

    srtc_wrq #(.WR_LAT(WR_LAT)) u_wrq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (slow_wr),
        .req       ('{sel: asel, data: bus_wdata}),
        .busy      (busy),
        .commit    (commit),
        .held      (held),
        .collide   (collide)
    );

    srtc_count #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .run      (ctl_run),
        .load_sec (commit && (held.sel == RG_TSEC)),
        .load_frc (commit && (held.sel == RG_TFRC)),
        .sec_val  (held.data),
        .frc_val  (held.data[FRAC_W-1:0]),
        .count    (count),
        .started  (started)
    );

    // slow-domain registers committed by the write queue
    always_ff @(posedge clk) begin
        if (rst) begin
            alm_sec <= '1;
            alm_frc <= '0;
            ctl_run <= 1'b0;
        end else if (commit) begin
            case (held.sel)
                RG_ASEC: alm_sec <= held.data;
                RG_AFRC: alm_frc <= held.data[FRAC_W-1:0];
                RG_CTRL: ctl_run <= held.data[B_RUN];
                default: ;
            endcase
        end
    end

    // fast register: interrupt enables
    always_ff @(posedge clk) begin
        if (rst) begin
            ien <= '0;
        end else if (ien_wr) begin
            ien <= '{nxt:  bus_wdata[B_NEXT], done: bus_wdata[B_DONE],
                     err:  bus_wdata[B_ERR],  alm:  bus_wdata[B_ALM]};
        end
    end

    assign alarm_hit   = (alm_sec != '1) && (count == {alm_sec, alm_frc});
    assign commit_stat = commit && (held.sel == RG_STAT);

    srtc_flags u_flg (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .commit_stat (commit_stat),
        .clr_err     (held.data[B_ERR]),
        .clr_alm     (held.data[B_ALM]),
        .clr_nval    (held.data[B_NVAL]),
        .collide     (collide),
        .alarm_hit   (alarm_hit),
        .stat_rd     (stat_rd),
        .busy        (busy),
        .ien         (ien),
        .flg         (flg),
        .irq         (irq)
    );

    always_comb begin
        stat_word         = '0;
        stat_word[B_BUSY] = busy;
        stat_word[B_NEXT] = !busy;
        stat_word[B_DONE] = flg.done;
        stat_word[B_ERR]  = flg.err;
        stat_word[B_ALM]  = flg.alm;
        stat_word[B_NVAL] = flg.nval;
        stat_word[B_SVIO] = 1'b0;
    end

    always_comb begin
        bus_rdata = '0;
        case (asel)
            RG_TSEC: bus_rdata = count[CW-1:FRAC_W];
            RG_TFRC: bus_rdata = DATA_W'(count[FRAC_W-1:0]);
            RG_ASEC: bus_rdata = alm_sec;
            RG_AFRC: bus_rdata = DATA_W'(alm_frc);
            RG_CTRL: bus_rdata[B_RUN] = ctl_run;
            RG_STAT: bus_rdata = stat_word;
            RG_IEN: begin
                bus_rdata[B_NEXT] = ien.nxt;
                bus_rdata[B_DONE] = ien.done;
                bus_rdata[B_ERR]  = ien.err;
                bus_rdata[B_ALM]  = ien.alm;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk #(
    parameter int WR_LAT = 4,
    parameter int CW     = 47
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_sel,
    input logic          bus_we,
    input logic [4:0]    bus_addr,
    input logic          irq,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          nval,
    input logic [3:0]    ien_bits,
    input logic          ctl_run,
    input logic [CW-1:0] count
);
    localparam int LW = $clog2(WR_LAT + 2);

    logic [LW-1:0] blen;
    logic          slow_addr;

    always_ff @(posedge clk) begin
        if (rst)       blen <= '0;
        else if (busy) blen <= blen + 1'b1;
        else           blen <= '0;
    end

    assign slow_addr = (bus_addr[1:0] == 2'b00) && (bus_addr[4:2] <= 3'd5);

    // R2: busy lasts exactly WR_LAT cycles
    p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (blen == LW'(WR_LAT)));

    // R2: every commit leaves write-complete set
    p_done_on_commit_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R3: colliding write flags an error
    p_err_on_collide_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_sel && bus_we && slow_addr) |=> err);

    // R6: enable writes never start the slow path
    p_ien_fast_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && bus_sel && bus_we && bus_addr == 5'h18) |=> !busy);

    // R7: counter frozen while stopped and no write commits
    p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (!ctl_run && !busy) |=> $stable(count));

    // R10: no enables, no interrupt
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (ien_bits == 4'b0000) |-> !irq);

    // R1: not-valid never comes back once cleared
    p_nval_stays_r1: assert property (@(posedge clk) disable iff (rst)
        !nval |=> !nval);

endmodule

bind sec_rtc sec_rtc_chk #(.WR_LAT(WR_LAT), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .irq      (irq),
    .busy     (busy),
    .done     (flg.done),
    .err      (flg.err),
    .nval     (flg.nval),
    .ien_bits (ien),
    .ctl_run  (ctl_run),
    .count    (count)
);

// File: tb/sec_rtc_tb.sv
module sec_rtc_tb;
    localparam int WR_LAT = 4;
    localparam logic [4:0] A_TSEC = 5'h00, A_TFRC = 5'h04, A_ASEC = 5'h08,
                           A_AFRC = 5'h0C, A_CTRL = 5'h10, A_STAT = 5'h14,
                           A_IEN  = 5'h18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    sec_rtc #(.FRAC_W(15), .WR_LAT(WR_LAT)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] st(input logic b, d, e, a, n);
        logic [31:0] w;
        w = '0;
        w[10] = b; w[9] = !b; w[8] = d; w[7] = e; w[4] = a; w[1] = n;
        return w;
    endfunction

    function automatic logic [46:0] adv(input logic [31:0] s, input logic [14:0] f,
                                        input int n);
        return {s, f} + 47'(n);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr_wait(input logic [4:0] a, input logic [31:0] d);
        bus_wr(a, d);
        repeat (WR_LAT) @(negedge clk);
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, 150000);
            summary();
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] s;
        logic [14:0] f;
        logic [46:0] m;
        int          n;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        #1 chk("R1 irq after reset", 32'(irq), 32'd0);
        @(negedge clk);
        bus_rd(A_STAT, r); chk("R1 status after reset", r, 32'h0000_0202);
        bus_rd(A_TSEC, r); chk("R1 seconds after reset", r, 32'd0);
        bus_rd(A_TFRC, r); chk("R1 fraction after reset", r, 32'd0);
        bus_rd(A_ASEC, r); chk("R1 alarm seconds after reset", r, 32'hFFFF_FFFF);
        bus_rd(A_IEN, r);  chk("R1 enables after reset", r, 32'd0);

        // R6 immediate enable write, R10 ready-for-next interrupt
        bus_wr(A_IEN, 32'h0000_0200);
        #1 chk("R6 enable acts at once (irq)", 32'(irq), 32'd1);
        @(negedge clk);
        bus_rd(A_STAT, r); chk("R6 no busy, no done", r, st(0, 0, 0, 0, 1));
        bus_wr(A_IEN, 32'h0);
        #1 chk("R10 irq drops with enable", 32'(irq), 32'd0);
        @(negedge clk);

        // R2 busy window on a control write
        bus_wr(A_CTRL, 32'hFFFF_FFFF);
        bus_rd(A_STAT, r); chk("R2 busy during slow write", r, st(1, 0, 0, 0, 1));
        bus_rd(A_CTRL, r); chk("R2 control unchanged before commit", r, 32'd0);
        repeat (WR_LAT - 2) @(negedge clk);
        bus_rd(A_STAT, r); chk("R4 status after commit", r, st(0, 1, 0, 0, 1));
        bus_rd(A_STAT, r); chk("R4 done cleared by read", r, st(0, 0, 0, 0, 1));
        bus_rd(A_CTRL, r); chk("R11 control reads only run bit", r, 32'h0000_0008);

        // R7 not started until seconds written
        ticks(5);
        bus_rd(A_TFRC, r); chk("R7 frozen before first seconds write", r, 32'd0);

        // R8 fraction carry
        wr_wait(A_TFRC, 32'hFFFF_7FFC);
        bus_rd(A_TFRC, r); chk("R11 fraction upper bits zero", r, 32'h0000_7FFC);
        wr_wait(A_TSEC, 32'd5);
        ticks(6);
        bus_rd(A_TSEC, r); chk("R8 seconds after carry", r, 32'd6);
        bus_rd(A_TFRC, r); chk("R8 fraction after carry", r, 32'd2);

        // R7 stop
        wr_wait(A_CTRL, 32'h0);
        ticks(3);
        bus_rd(A_TFRC, r); chk("R7 no advance when disabled", r, 32'd2);
        bus_rd(A_STAT, r);

        // R3 collision
        bus_wr(A_ASEC, 32'h11);
        bus_wr(A_ASEC, 32'h22);
        bus_rd(A_STAT, r); chk("R3 error on busy write", r, st(1, 0, 1, 0, 1));
        bus_wr(A_IEN, 32'h0000_0080);
        #1 chk("R10 irq from error flag", 32'(irq), 32'd1);
        repeat (WR_LAT) @(negedge clk);
        bus_rd(A_ASEC, r); chk("R3 second write dropped", r, 32'h11);

        // R5 write-one-to-clear
        wr_wait(A_STAT, 32'h0);
        bus_rd(A_STAT, r); chk("R5 zero bits leave flags", r, st(0, 1, 1, 0, 1));
        wr_wait(A_STAT, 32'h82);
        bus_rd(A_STAT, r); chk("R5 ones clear flags", r, st(0, 1, 0, 0, 0));
        #1 chk("R10 irq off after clear", 32'(irq), 32'd0);
        bus_wr(A_IEN, 32'h0);

        // R4 read in the commit cycle
        bus_wr(A_AFRC, 32'h0);
        repeat (WR_LAT - 1) @(negedge clk);
        bus_rd(A_STAT, r); chk("R4 read at commit sees busy", r, st(1, 0, 0, 0, 0));
        bus_rd(A_STAT, r); chk("R4 commit wins over read", r, st(0, 1, 0, 0, 0));
        bus_rd(A_STAT, r); chk("R4 cleared after next read", r, st(0, 0, 0, 0, 0));

        // R9 alarm match
        wr_wait(A_CTRL, 32'h8);
        wr_wait(A_ASEC, 32'h20);
        wr_wait(A_TFRC, 32'h7FFE);
        wr_wait(A_TSEC, 32'h1F);
        bus_rd(A_STAT, r);
        ticks(1);
        @(negedge clk);
        bus_rd(A_STAT, r); chk("R9 no alarm one before", r, st(0, 0, 0, 0, 0));
        ticks(1);
        @(negedge clk);
        bus_rd(A_STAT, r); chk("R9 alarm on equal", r, st(0, 0, 0, 1, 0));
        bus_wr(A_IEN, 32'h10);
        #1 chk("R10 irq from alarm", 32'(irq), 32'd1);
        ticks(1);
        wr_wait(A_STAT, 32'h10);
        bus_rd(A_STAT, r); chk("R5 alarm cleared", r, st(0, 1, 0, 0, 0));
        #1 chk("R10 irq off after alarm clear", 32'(irq), 32'd0);
        bus_wr(A_IEN, 32'h0);

        // R9 all-ones disables
        wr_wait(A_ASEC, 32'hFFFF_FFFF);
        wr_wait(A_TFRC, 32'h0);
        wr_wait(A_TSEC, 32'hFFFF_FFFF);
        @(negedge clk);
        bus_rd(A_STAT, r); chk("R9 all-ones never matches", r, st(0, 1, 0, 0, 0));

        // random loads and runs (R7, R8, R3 collisions)
        for (int k = 0; k < 16; k++) begin
            s = $urandom;
            f = ($urandom % 2) ? 15'(32'h7FFF - ($urandom % 8)) : 15'($urandom);
            n = 1 + int'($urandom % 40);
            wr_wait(A_TFRC, 32'(f));
            bus_wr(A_TSEC, s);
            if ($urandom % 2) bus_wr(A_TSEC, ~s);
            repeat (WR_LAT) @(negedge clk);
            ticks(n);
            m = adv(s, f, n);
            bus_rd(A_TSEC, r); chk("R7 random seconds", r, m[46:15]);
            bus_rd(A_TFRC, r); chk("R8 random fraction", r, 32'(m[14:0]));
        end

        summary();
    end

endmodule